// File: doc/BRIEF.md
# External Event Counter Channel

This block is one channel of a timer that counts events on an external pin. After software places a reload value in the channel and fires the start trigger, the channel copies that value into its down-counter and waits. Each rising edge seen on the pin lowers the counter by one. When an edge brings the counter to zero, the channel raises a one-clock interrupt pulse. The edge after that restores the reload value, and counting goes on with no help from software. The interrupt therefore marks every group of a programmed number of events.

Software reaches the channel through a small register port with a synchronous write and a combinational read. A stop trigger freezes the counter at its current value. A mode register, which has no effect on counting, is write-protected while the channel runs. A unit-level enable input acts as the power switch: while it is low, every write is discarded and all channel state returns to its reset value.

Top module: `evt_cnt_chan`

## Requirements
- R1: While `unit_en` is 0, every register write is discarded. The reload value, counter, mode and run flag return to 0 and `irq` is 0. Reset leaves the same state.
- R2: While running, each rising edge of `evt_in` lowers the counter by one, 3 clocks after the pin rises (2 synchroniser stages plus the counter register). A pin held high counts only once.
- R3: An edge that arrives while the counter reads 0 loads the reload value into the counter in place of decrementing.
- R4: `irq` is high for exactly one clock. It starts at the same clock edge at which an event takes the counter to 0, including a reload of 0.
- R5: Writing CTRL (address 3) with bit 0 set sets the run flag and copies the reload value into the counter. No event is counted in that cycle.
- R6: Writing CTRL with bit 1 set clears the run flag. The counter keeps its value, and later edges do not change it.
- R7: If bits 0 and 1 are both set in one CTRL write, stop wins: the run flag is 0 afterwards and the counter is not reloaded.
- R8: Reading CTRL returns 0 in bits 1:0. Bit 2 holds the run flag and the upper bits read 0.
- R9: The reload register (address 0) can be written while running and is used at the next reload. If a write and a reload fall in the same cycle, the reload uses the value held before the write.
- R10: Writes to MODE (address 2, 8 bits) are discarded while the run flag is 1 and stored while it is 0.
- R11: Address 1 reads the live counter, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_en | input | 1 | Unit enable; low holds the channel in reset and blocks writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 reload, 1 counter, 2 mode, 3 control) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, combinational |
| evt_in | input | 1 | External event pin, asynchronous |
| irq | output | 1 | One-clock pulse when the count reaches zero |

## Verification
Two pairs of events are made to coincide. First, a write to the reload register is timed to land on the clock edge at which a counted event reloads a counter sitting at zero. The check is that the counter takes the old reload value, the register reads back the new one, and the new value only appears at the next reload. Second, start and stop are written together in one control access. The check is that the run flag stays clear, the counter keeps its previous value rather than reloading, and later pin edges do not move it.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_RELOAD = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_MODE   = 2'd2,
      SEL_CTRL   = 2'd3
   } reg_sel_e;

   localparam int BIT_START = 0;
   localparam int BIT_STOP  = 1;
   localparam int BIT_RUN   = 2;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pin,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("evt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   stage_q[0] <= 1'b0;
               else if (clr) stage_q[0] <= 1'b0;
               else          stage_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   stage_q[gi] <= 1'b0;
               else if (clr) stage_q[gi] <= 1'b0;
               else          stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= 1'b0;
      else if (clr) last_q <= 1'b0;
      else          last_q <= stage_q[STAGES-1];
   end

   assign rise = stage_q[STAGES-1] & ~last_q;

   p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs #(
   parameter int CNT_W  = 16,
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              reload_we,
   input  logic              mode_we,
   input  logic              lock,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  reload_q,
   output logic [MODE_W-1:0] mode_q
);
   initial begin
      if (MODE_W > CNT_W) $error("evt_cfg_regs: MODE_W must not exceed CNT_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reload_q <= '0;
      else if (!unit_en)   reload_q <= '0;
      else if (reload_we)  reload_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode_q <= '0;
      else if (!unit_en)         mode_q <= '0;
      else if (mode_we && !lock) mode_q <= wdata[MODE_W-1:0];
   end

   p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(mode_q) || !$past(unit_en)));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unit_en,
   input  logic             start,
   input  logic             stop,
   input  logic             rise,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count_q,
   output logic             run_q,
   output logic             irq_q
);
   initial begin
      if (CNT_W < 2) $error("evt_count_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] next_cnt;
   logic             take;

   assign next_cnt = (count_q == '0) ? reload_val : count_q - 1'b1;
   assign take     = run_q && rise && !start && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         run_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else if (!unit_en) begin
         count_q <= '0;
         run_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= take && (next_cnt == '0);
         if (stop) begin
            run_q <= 1'b0;
         end else if (start) begin
            run_q   <= 1'b1;
            count_q <= reload_val;
         end else if (take) begin
            count_q <= next_cnt;
         end
      end
   end

   p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   p_irq_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (count_q == '0));
   p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start && unit_en) |=> $stable(count_q));
   p_unit_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_en |=> (count_q == '0 && !run_q && !irq_q));
endmodule

// File: rtl/evt_cnt_chan.sv
module evt_cnt_chan
   import evt_cnt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              evt_in,
   output logic              irq
);
   localparam int CTRL_BITS = BIT_RUN + 1;

   initial begin
      if (CNT_W < CTRL_BITS) $error("evt_cnt_chan: CNT_W too small for control bits");
   end

   logic              wr_ok, start_t, stop_t, reload_we, mode_we, rise;
   logic [CNT_W-1:0]  reload_q, count_q;
   logic [MODE_W-1:0] mode_q;
   logic              run_q;

   assign wr_ok     = wr_en && unit_en;
   assign reload_we = wr_ok && (reg_sel_e'(wr_addr) == SEL_RELOAD);
   assign mode_we   = wr_ok && (reg_sel_e'(wr_addr) == SEL_MODE);
   assign start_t   = wr_ok && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_data[BIT_START];
   assign stop_t    = wr_ok && (reg_sel_e'(wr_addr) == SEL_CTRL) && wr_data[BIT_STOP];

   evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .clr (!unit_en),
      .pin (evt_in),
      .rise (rise)
   );

   evt_cfg_regs #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_cfg (
      .clk (clk),
      .rst_n (rst_n),
      .unit_en (unit_en),
      .reload_we (reload_we),
      .mode_we (mode_we),
      .lock (run_q),
      .wdata (wr_data),
      .reload_q (reload_q),
      .mode_q (mode_q)
   );

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk (clk),
      .rst_n (rst_n),
      .unit_en (unit_en),
      .start (start_t),
      .stop (stop_t),
      .rise (rise),
      .reload_val (reload_q),
      .count_q (count_q),
      .run_q (run_q),
      .irq_q (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_addr))
         SEL_RELOAD: rd_data = reload_q;
         SEL_COUNT:  rd_data = count_q;
         SEL_MODE:   rd_data[MODE_W-1:0] = mode_q;
         SEL_CTRL:   rd_data[BIT_RUN] = run_q;
         default:    rd_data = '0;
      endcase
   end

   p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_t |=> !run_q);
   p_start_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_t && !stop_t) |=> run_q);
endmodule

// File: tb/evt_cnt_chan_tb.sv
module evt_cnt_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        unit_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        evt_in = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   int irq_seen = 0;
   bit done = 0;

   always #4 clk = ~clk;

   evt_cnt_chan u_dut (
      .clk (clk), .rst_n (rst_n), .unit_en (unit_en),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_addr (rd_addr), .rd_data (rd_data),
      .evt_in (evt_in), .irq (irq)
   );

   always @(negedge clk) if (irq) irq_seen++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
      rd_addr = a;
      #1;
      chk(req, int'(rd_data), exp);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk) evt_in = 1'b1;
      repeat (3) @(negedge clk);
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      rd_chk("R1 reload", 2'd0, 0);
      rd_chk("R1 count", 2'd1, 0);
      rd_chk("R1 mode", 2'd2, 0);
      rd_chk("R1 ctrl", 2'd3, 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_basic();
      int base;
      wr(2'd0, 16'd3);
      wr(2'd3, 16'h1);
      rd_chk("R5 load", 2'd1, 3);
      rd_chk("R8 ctrl run, triggers read 0", 2'd3, 4);
      base = irq_seen;
      pulse(); rd_chk("R2 step1", 2'd1, 2);
      pulse(); rd_chk("R2 step2", 2'd1, 1);
      chk("R4 no early irq", irq_seen - base, 0);
      pulse(); rd_chk("R2 reach zero", 2'd1, 0);
      chk("R4 one pulse", irq_seen - base, 1);
      pulse(); rd_chk("R3 reload", 2'd1, 3);
      chk("R4 none on reload", irq_seen - base, 1);
   endtask

   task automatic t_steady();
      @(negedge clk) evt_in = 1'b1;
      repeat (12) @(negedge clk);
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
      rd_chk("R2 held pin counts once", 2'd1, 2);
   endtask

   task automatic t_mode_stop();
      wr(2'd2, 16'h5A);
      rd_chk("R10 locked while running", 2'd2, 0);
      wr(2'd1, 16'd9);
      rd_chk("R11 count write ignored", 2'd1, 2);
      wr(2'd3, 16'h2);
      rd_chk("R6 run cleared", 2'd3, 0);
      pulse(); pulse();
      rd_chk("R6 count held", 2'd1, 2);
      wr(2'd2, 16'h5A);
      rd_chk("R10 written while stopped", 2'd2, 16'h5A);
   endtask

   task automatic t_both();
      wr(2'd0, 16'd8);
      wr(2'd3, 16'h3);
      rd_chk("R7 stop wins run flag", 2'd3, 0);
      rd_chk("R7 no reload", 2'd1, 2);
      pulse();
      rd_chk("R7 still idle", 2'd1, 2);
   endtask

   task automatic t_reload_change();
      int base;
      wr(2'd0, 16'd2);
      wr(2'd3, 16'h1);
      wr(2'd0, 16'd5);
      base = irq_seen;
      pulse(); pulse();
      rd_chk("R9 zero", 2'd1, 0);
      chk("R4 irq", irq_seen - base, 1);
      pulse();
      rd_chk("R9 new value at reload", 2'd1, 5);
      repeat (5) pulse();
      rd_chk("R9 zero again", 2'd1, 0);
      // reload edge and reload write on the same clock edge
      @(negedge clk) evt_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd7;
      @(negedge clk);
      wr_en = 1'b0;
      evt_in = 1'b0;
      repeat (3) @(negedge clk);
      rd_chk("R9 coincident reload uses old", 2'd1, 5);
      rd_chk("R9 coincident write stored", 2'd0, 7);
      repeat (6) pulse();
      rd_chk("R9 later reload uses new", 2'd1, 7);
      chk("R4 irq total", irq_seen - base, 3);
   endtask

   task automatic t_unit_off();
      @(negedge clk) unit_en = 1'b0;
      @(negedge clk);
      rd_chk("R1 off count", 2'd1, 0);
      rd_chk("R1 off reload", 2'd0, 0);
      rd_chk("R1 off mode", 2'd2, 0);
      rd_chk("R1 off run", 2'd3, 0);
      wr(2'd0, 16'd4);
      wr(2'd3, 16'h1);
      @(negedge clk) unit_en = 1'b1;
      @(negedge clk);
      rd_chk("R1 write while off dropped", 2'd0, 0);
      rd_chk("R1 start while off dropped", 2'd3, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      @(negedge clk) unit_en = 1'b1;
      t_basic();
      t_steady();
      t_mode_stop();
      t_both();
      t_reload_change();
      t_unit_off();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule